// File: doc/BRIEF.md
# Multi-cycle context sequencer

This block sits between a configuration cache and one processing element of a reconfigurable array. The cache offers one context word per cycle. The sequencer latches each accepted word, together with the two operands that travel with it, into a context register. In the following cycle the processing element executes that word. Most words finish in that single cycle, so the array can issue a new word on every clock.

A multiply word can carry a duration of two or more cycles. When such a word reaches the context register, a small state machine takes control of the datapath. It runs a shift-and-add multiply, one multiplier bit per cycle, for exactly the encoded number of cycles. While the operation runs, `ctx_ready` is low, so the cache stalls and holds its next word. `ctx_ready` rises again in the last cycle of the operation. The next word is therefore accepted at the same edge that completes the multiply, and no issue slot is lost.

Every executed word produces a one-cycle `done` pulse. The result register updates at the same edge that raises `done`.

Top module: `ctx_seq_pe`

## Requirements
- R1: After reset, `ctx_ready` is 1 and `busy`, `done`, `dp_en` and `result` are all 0.
- R2: The context word holds the opcode in bits [5:4] and the duration in bits [3:0]. The opcodes are 0 for add, 1 for subtract (a minus b), 2 for exclusive-or and 3 for multiply. `a_in` and `b_in` are sampled at the same edge as the word, and results are taken modulo 2^8.
- R3: A word accepted at a clock edge (`ctx_valid` and `ctx_ready` both high) executes in the next cycle. A single-cycle word shows its result with `done` high in the cycle after that.
- R4: Single-cycle words presented on consecutive cycles are accepted one per cycle and produce `done` on consecutive cycles, with their results in order.
- R5: A multiply word whose duration is 0 or 1 executes in one cycle and yields a when b[0] is 1, and 0 otherwise.
- R6: A multiply word with duration N of 2 or more keeps `busy` high for exactly N cycles. Its result is a × (b mod 2^N) mod 2^8, so steps beyond the eighth add nothing.
- R7: After a multi-cycle word is accepted, `ctx_ready` is low for N−1 cycles and high in the last execution cycle. While `busy` is low, `ctx_ready` is high.
- R8: A word offered while `ctx_ready` is low is not taken. Only the word present in the cycle where `ctx_ready` is high executes.
- R9: `done` is high only in the cycle after a word finished executing, and `result` changes only together with `done`. When no valid word is offered, `done` stays low and `result` holds.
- R10: For add, subtract and exclusive-or the duration field has no effect: the word takes one cycle and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctx_valid | input | 1 | The cache presents a context word |
| ctx_word | input | 6 | Context word: opcode [5:4], duration [3:0] |
| a_in | input | 8 | First operand, sampled with the word |
| b_in | input | 8 | Second operand (the multiplier for multiply), sampled with the word |
| ctx_ready | output | 1 | The sequencer takes a word at this edge; low means the cache must stall |
| dp_en | output | 1 | The context register holds a word the datapath executes this cycle |
| dp_op | output | 2 | Opcode driving the datapath this cycle |
| busy | output | 1 | The state machine owns the datapath for a multi-cycle operation |
| done | output | 1 | One-cycle pulse: a word finished and `result` has just updated |
| result | output | 8 | Result register |

## Verification
The cycle of interest is the last cycle of a multi-cycle multiply. In that cycle the operation completes, `ctx_ready` returns, and a waiting word is captured. The next cycle then shows the multiply's result and `done` while the new word already executes.

The bench provokes this by holding a word on the cache side during the whole stall. It first offers an unrelated word early in the stall, then swaps it for the intended one. It judges the outcome from the exact cycles in which `ctx_ready` rises, from the two consecutive `done` pulses and their result values, and from the absence of any third pulse from the discarded word.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_XOR = 2'd2,
    OP_MUL = 2'd3
  } op_e;

  typedef enum logic {
    S_ISSUE = 1'b0,
    S_MULTI = 1'b1
  } seq_state_e;
endpackage

// File: rtl/ctx_hold_reg.sv
module ctx_hold_reg
  import ctx_seq_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DURW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic            in_valid,
  input  op_e             in_op,
  input  logic [DURW-1:0] in_dur,
  input  logic [DW-1:0]   in_a,
  input  logic [DW-1:0]   in_b,
  output logic            cur_valid,
  output op_e             cur_op,
  output logic [DURW-1:0] cur_dur,
  output logic [DW-1:0]   cur_a,
  output logic [DW-1:0]   cur_b
);
  logic take;
  assign take = load_en && in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_valid <= 1'b0;
    end else if (load_en) begin
      cur_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_op  <= OP_ADD;
      cur_dur <= '0;
      cur_a   <= '0;
      cur_b   <= '0;
    end else if (take) begin
      cur_op  <= in_op;
      cur_dur <= in_dur;
      cur_a   <= in_a;
      cur_b   <= in_b;
    end
  end
endmodule

// File: rtl/ctx_step_fsm.sv
module ctx_step_fsm
  import ctx_seq_pkg::*;
#(
  parameter int DURW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cur_valid,
  input  op_e             cur_op,
  input  logic [DURW-1:0] cur_dur,
  output logic            first_step,
  output logic            is_multi,
  output logic            exec_done,
  output logic            issue_ok
);
  seq_state_e      state_q, state_n;
  logic [DURW-1:0] cnt_q, cnt_n;
  logic            last_step;

  assign is_multi   = cur_valid && (cur_op == OP_MUL) && (cur_dur >= DURW'(2));
  assign first_step = (state_q == S_ISSUE);
  assign last_step  = is_multi && (cnt_q == (cur_dur - DURW'(1)));
  assign exec_done  = cur_valid && (!is_multi || last_step);
  assign issue_ok   = !is_multi || last_step;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    case (state_q)
      S_ISSUE: begin
        if (is_multi) begin
          state_n = S_MULTI;
          cnt_n   = DURW'(1);
        end
      end
      S_MULTI: begin
        if (last_step) begin
          state_n = S_ISSUE;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + DURW'(1);
        end
      end
      default: begin
        state_n = S_ISSUE;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_ISSUE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end
endmodule

// File: rtl/pe_exec_dp.sv
module pe_exec_dp
  import ctx_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cur_valid,
  input  op_e           cur_op,
  input  logic [DW-1:0] cur_a,
  input  logic [DW-1:0] cur_b,
  input  logic          first_step,
  input  logic          exec_done,
  output logic [DW-1:0] res_q,
  output logic          done_q
);
  logic [DW-1:0] acc_q, mc_q, mp_q;
  logic [DW-1:0] acc_c, mc_c, mp_c, acc_n, alu_out;
  logic          step_en;

  assign step_en = cur_valid && (cur_op == OP_MUL);
  assign acc_c   = first_step ? '0    : acc_q;
  assign mc_c    = first_step ? cur_a : mc_q;
  assign mp_c    = first_step ? cur_b : mp_q;
  assign acc_n   = acc_c + (mp_c[0] ? mc_c : '0);

  always_comb begin
    case (cur_op)
      OP_ADD:  alu_out = cur_a + cur_b;
      OP_SUB:  alu_out = cur_a - cur_b;
      OP_XOR:  alu_out = cur_a ^ cur_b;
      default: alu_out = acc_n;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      mc_q  <= '0;
      mp_q  <= '0;
    end else if (step_en) begin
      acc_q <= acc_n;
      mc_q  <= mc_c << 1;
      mp_q  <= mp_c >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (exec_done) begin
      res_q <= alu_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= exec_done;
    end
  end
endmodule

// File: rtl/ctx_seq_pe.sv
module ctx_seq_pe
  import ctx_seq_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DURW     = 4,
  parameter int SYNC_LEN = 2,
  localparam int CW      = DURW + OP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctx_valid,
  input  logic [CW-1:0] ctx_word,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  output logic          ctx_ready,
  output logic          dp_en,
  output logic [1:0]    dp_op,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result
);
  logic            core_rst_n;
  logic            cur_valid, first_step, is_multi, exec_done, issue_ok;
  op_e             cur_op, in_op;
  logic [DURW-1:0] cur_dur, in_dur;
  logic [DW-1:0]   cur_a, cur_b;

  generate
    if (SYNC_LEN < 2) begin : g_sync_one
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
      assign core_rst_n = sync_q;
    end else begin : g_sync_chain
      logic [SYNC_LEN-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_LEN-2:0], 1'b1};
      end
      assign core_rst_n = sync_q[SYNC_LEN-1];
    end
  endgenerate

  assign in_op  = op_e'(ctx_word[CW-1 -: OP_W]);
  assign in_dur = ctx_word[DURW-1:0];

  ctx_hold_reg #(.DW(DW), .DURW(DURW)) u_hold (
    .clk(clk), .rst_n(core_rst_n), .load_en(issue_ok),
    .in_valid(ctx_valid), .in_op(in_op), .in_dur(in_dur),
    .in_a(a_in), .in_b(b_in),
    .cur_valid(cur_valid), .cur_op(cur_op), .cur_dur(cur_dur),
    .cur_a(cur_a), .cur_b(cur_b)
  );

  ctx_step_fsm #(.DURW(DURW)) u_fsm (
    .clk(clk), .rst_n(core_rst_n), .cur_valid(cur_valid),
    .cur_op(cur_op), .cur_dur(cur_dur),
    .first_step(first_step), .is_multi(is_multi),
    .exec_done(exec_done), .issue_ok(issue_ok)
  );

  pe_exec_dp #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(core_rst_n), .cur_valid(cur_valid),
    .cur_op(cur_op), .cur_a(cur_a), .cur_b(cur_b),
    .first_step(first_step), .exec_done(exec_done),
    .res_q(result), .done_q(done)
  );

  assign ctx_ready = issue_ok;
  assign dp_en     = cur_valid;
  assign dp_op     = cur_op;
  assign busy      = is_multi;
endmodule

// File: rtl/ctx_seq_pe_chk.sv
module ctx_seq_pe_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctx_ready,
  input logic          dp_en,
  input logic [1:0]    dp_op,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] result
);
  a_r7_idle_means_ready: assert property (
    @(posedge clk) disable iff (!rst_n) !busy |-> ctx_ready);

  a_r7_stall_keeps_op: assert property (
    @(posedge clk) disable iff (!rst_n)
    (busy && !ctx_ready) |=> (busy && $stable(dp_op) && dp_en));

  a_r9_result_only_with_done: assert property (
    @(posedge clk) disable iff (!rst_n) !done |-> $stable(result));

  a_r9_done_follows_exec: assert property (
    @(posedge clk) disable iff (!rst_n) done |-> $past(dp_en));

  a_r10_simple_ops_not_busy: assert property (
    @(posedge clk) disable iff (!rst_n)
    (dp_en && dp_op != 2'd3) |-> !busy);

  a_r6_busy_has_word: assert property (
    @(posedge clk) disable iff (!rst_n) busy |-> (dp_en && dp_op == 2'd3));
endmodule

bind ctx_seq_pe ctx_seq_pe_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctx_ready(ctx_ready), .dp_en(dp_en),
  .dp_op(dp_op), .busy(busy), .done(done), .result(result)
);

// File: tb/tb_ctx_seq_pe.sv
module tb_ctx_seq_pe;
  typedef struct packed {
    logic [1:0] op;
    logic [3:0] dur;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] exp;
    logic [4:0] n;
  } vec_t;

  // opcodes per R2: 0 add, 1 sub, 2 xor, 3 mul
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd0,  8'd25,  8'd17,  8'd42,  5'd1},  // R2 add
    '{2'd1, 4'd0,  8'd10,  8'd20,  8'd246, 5'd1},  // R2 sub wraps
    '{2'd2, 4'd7,  8'hF0,  8'h3C,  8'hCC,  5'd1},  // R10 dur ignored
    '{2'd3, 4'd0,  8'd13,  8'd7,   8'd13,  5'd1},  // R5 b0=1
    '{2'd3, 4'd1,  8'd13,  8'd6,   8'd0,   5'd1},  // R5 b0=0
    '{2'd3, 4'd4,  8'd13,  8'hB6,  8'd78,  5'd4},  // R6 low 4 bits of b
    '{2'd3, 4'd8,  8'd15,  8'd15,  8'd225, 5'd8},  // R6 full width
    '{2'd3, 4'd15, 8'd20,  8'd13,  8'd4,   5'd15}, // R6 beyond width, wraps
    '{2'd3, 4'd2,  8'hFF,  8'd3,   8'd253, 5'd2},  // R6 minimum multi
    '{2'd0, 4'd15, 8'd200, 8'd100, 8'd44,  5'd1}   // R10 add with dur
  };

  logic       clk;
  logic       rst_n;
  logic       ctx_valid;
  logic [5:0] ctx_word;
  logic [7:0] a_in, b_in;
  logic       ctx_ready, dp_en, busy, done;
  logic [1:0] dp_op;
  logic [7:0] result;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  ctx_seq_pe dut (
    .clk(clk), .rst_n(rst_n), .ctx_valid(ctx_valid), .ctx_word(ctx_word),
    .a_in(a_in), .b_in(b_in), .ctx_ready(ctx_ready), .dp_en(dp_en),
    .dp_op(dp_op), .busy(busy), .done(done), .result(result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [1:0] op, input logic [3:0] dur,
                       input logic [7:0] a, input logic [7:0] b);
    ctx_valid = v;
    ctx_word  = {op, dur};
    a_in      = a;
    b_in      = b;
  endtask

  initial begin
    int k, bcnt;
    logic [7:0] held;
    rst_n = 1'b0;
    drive(1'b0, 2'd0, 4'd0, 8'd0, 8'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(ctx_ready === 1'b1, "R1 ready", ctx_ready, 1);
    chk(busy === 1'b0,      "R1 busy",  busy, 0);
    chk(done === 1'b0,      "R1 done",  done, 0);
    chk(dp_en === 1'b0,     "R1 dp_en", dp_en, 0);
    chk(result === 8'd0,    "R1 result", result, 0);

    // table walk: R3 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i].op, VEC[i].dur, VEC[i].a, VEC[i].b);
      k = 0;
      bcnt = 0;
      do begin
        @(negedge clk);
        k++;
        if (k == 1) drive(1'b0, 2'd0, 4'd0, 8'd0, 8'd0);
        if (busy) bcnt++;
      end while (!done && k < 40);
      chk(result === VEC[i].exp, "R6/R5/R2 result", result, VEC[i].exp);
      chk(k == int'(VEC[i].n) + 1, "R3 latency", k, int'(VEC[i].n) + 1);
      chk(bcnt == ((VEC[i].n >= 2) ? int'(VEC[i].n) : 0), "R6/R10 busy cycles",
          bcnt, (VEC[i].n >= 2) ? int'(VEC[i].n) : 0);
      @(negedge clk);
    end

    // R4 back-to-back single-cycle words
    drive(1'b1, 2'd0, 4'd0, 8'd1, 8'd2);
    @(negedge clk);
    drive(1'b1, 2'd1, 4'd0, 8'd9, 8'd4);
    @(negedge clk);
    chk(done === 1'b1 && result === 8'd3, "R4 first", result, 3);
    drive(1'b1, 2'd2, 4'd0, 8'h0F, 8'hFF);
    @(negedge clk);
    chk(done === 1'b1 && result === 8'd5, "R4 second", result, 5);
    drive(1'b0, 2'd0, 4'd0, 8'd0, 8'd0);
    @(negedge clk);
    chk(done === 1'b1 && result === 8'hF0, "R4 third", result, 240);
    @(negedge clk);

    // R9 bubbles: no done, result held
    held = result;
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R9 no done on bubble", done, 0);
    chk(result === held, "R9 result held", result, held);

    // R7 R8: multiply completes while next word waits; stale word dropped
    drive(1'b1, 2'd3, 4'd3, 8'd9, 8'd5);
    @(negedge clk);
    chk(ctx_ready === 1'b0, "R7 ready low step1", ctx_ready, 0);
    drive(1'b1, 2'd2, 4'd0, 8'hAA, 8'h55);
    @(negedge clk);
    chk(ctx_ready === 1'b0, "R7 ready low step2", ctx_ready, 0);
    drive(1'b1, 2'd0, 4'd0, 8'd3, 8'd4);
    @(negedge clk);
    chk(ctx_ready === 1'b1, "R7 ready in last step", ctx_ready, 1);
    chk(done === 1'b0, "R9 no early done", done, 0);
    @(negedge clk);
    drive(1'b0, 2'd0, 4'd0, 8'd0, 8'd0);
    chk(done === 1'b1 && result === 8'd45, "R6 multi result", result, 45);
    @(negedge clk);
    chk(done === 1'b1 && result === 8'd7, "R8 waiting word result", result, 7);
    @(negedge clk);
    chk(done === 1'b0, "R8 stale word not executed", done, 0);
    chk(result === 8'd7, "R8 result unchanged", result, 7);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule